// File: doc/BRIEF.md
# DMA Channel Address Generator

This block is the address sequencer of one DMA channel. It produces a read address and a write address for each word moved, and it leaves the data path and the bus fabric to other blocks. Each pointer walks three nested loops. Words inside a burst advance by a signed burst step. Bursts inside a transfer advance by a signed transfer step. A wrap counter, also counted in bursts, rebases the pointer by a signed wrap step. The source and destination pointers each have their own set of steps and their own wrap counter.

Software places the shadow values on the configuration inputs and pulses `run_set`. The channel then copies the starting addresses and the loop counts into its working registers and waits for triggers. Each trigger starts one burst. In one-shot mode a single trigger starts the whole transfer. In continuous mode the channel reloads the shadow values after each transfer and stays armed. A channel interrupt pulse marks either the start or the end of a transfer. A trigger that arrives while an earlier one is still pending is recorded as an overflow.

The size, step and mode inputs are sampled live and must be held steady while the channel is busy. Steps are 16-bit two's complement values, sign-extended and added modulo the address width.

Top module: `dma_addr_seq`

## Requirements
- R1: After `rst_n` is asserted, `rd_en`, `wr_en`, `busy`, `ch_int`, `ovf_flag` and `ovf_int` are all 0.
- R2: A burst issues `burst_m1`+1 word strobes on consecutive cycles. `rd_en` and `wr_en` are high together. Between words, `rd_addr` advances by `src_bstep` and `wr_addr` by `dst_bstep`, each sign-extended and added modulo 2^AW.
- R3: A transfer has `xfer_len` bursts, and a value of 0 behaves as 1. Between bursts without a wrap, each pointer advances from its last word address by its transfer step (`src_xstep` or `dst_xstep`).
- R4: Each pointer has its own wrap counter, loaded with its wrap length. At every burst end the counter either decrements or, when its value is 1 or 0, wraps. On a wrap, the beginning address becomes beginning + wrap step, the current address takes that same value, the transfer step is not applied and the counter is reloaded.
- R5: `run_set`, while the channel is not busy, copies the four shadow addresses, `xfer_len` and both wrap lengths into the working registers and raises `busy`. While the channel is busy, `run_set` has no effect.
- R6: A trigger sampled at clock edge E while the channel is busy and no burst is active starts a burst at edge E+1, so the first strobe is visible after E+1. Triggers sampled while the channel is not busy are dropped and leave nothing pending.
- R7: With `one_shot`=1, one trigger runs every burst of the transfer back to back, with no idle cycle between bursts.
- R8: At the end of a transfer with `cont_mode`=1, the shadow values are reloaded and `busy` stays 1. With `cont_mode`=0, `busy` drops and any pending trigger is discarded.
- R9: With `int_en`=1, `ch_int` pulses for one cycle. With `int_at_end`=0 the pulse falls in the cycle of the first strobe of a transfer. With `int_at_end`=1 it falls in the cycle after the last strobe. With `int_en`=0, `ch_int` stays 0.
- R10: A trigger sampled while one is already pending, and not consumed by a burst start at that same edge, sets `ovf_flag`. The flag stays set until `clr_err`, and `clr_err` wins over a new overflow. `ovf_int` equals `ovf_flag` AND `ovf_int_en`.
- R11: `clr_trig` discards a pending trigger, so the burst that trigger would have started never runs.
- R12: `hard_rst` returns the channel to idle at the next edge, clearing `busy`, strobes, pending trigger and `ovf_flag`. `run_set` and `trig` sampled at the edge right after `hard_rst` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hard_rst | input | 1 | Synchronous channel reset to idle |
| run_set | input | 1 | Load the shadow values and arm the channel |
| trig | input | 1 | Trigger event, one per burst |
| clr_trig | input | 1 | Discard the pending trigger |
| clr_err | input | 1 | Clear the overflow flag |
| sh_src_beg | input | AW | Shadow source beginning address |
| sh_src_cur | input | AW | Shadow source current address |
| sh_dst_beg | input | AW | Shadow destination beginning address |
| sh_dst_cur | input | AW | Shadow destination current address |
| burst_m1 | input | CW | Words per burst minus one |
| src_bstep | input | SW | Signed source step between words |
| dst_bstep | input | SW | Signed destination step between words |
| xfer_len | input | CW | Bursts per transfer |
| src_xstep | input | SW | Signed source step between bursts |
| dst_xstep | input | SW | Signed destination step between bursts |
| src_wrap_len | input | CW | Source bursts per wrap |
| src_wstep | input | SW | Signed source wrap step |
| dst_wrap_len | input | CW | Destination bursts per wrap |
| dst_wstep | input | SW | Signed destination wrap step |
| one_shot | input | 1 | One trigger runs the whole transfer |
| cont_mode | input | 1 | Re-arm after each transfer |
| int_at_end | input | 1 | 1: interrupt at transfer end, 0: at transfer start |
| int_en | input | 1 | Channel interrupt enable |
| ovf_int_en | input | 1 | Overflow interrupt enable |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | AW | Source word address |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Destination word address |
| busy | output | 1 | Channel armed |
| ch_int | output | 1 | Channel interrupt pulse |
| ovf_flag | output | 1 | Sticky trigger overflow flag |
| ovf_int | output | 1 | Overflow interrupt |

## Verification
A trigger sampled at one edge gives its first strobe after the following edge. The bench checks this latency directly by sampling `rd_en` at the two falling edges that follow the trigger. A start-of-transfer interrupt is due in the same cycle as the first strobe, and an end-of-transfer interrupt one cycle after the last strobe. The monitor therefore samples every falling edge, pops one expected address pair per strobe, and derives the expected `ch_int` from the first/last marks on the popped items. Flags such as overflow and busy are checked a full cycle after the edge that sets or clears them.

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hard_rst,
  input  logic          run_set,
  input  logic          trig,
  input  logic          clr_trig,
  input  logic          clr_err,
  input  logic [AW-1:0] sh_src_beg,
  input  logic [AW-1:0] sh_src_cur,
  input  logic [AW-1:0] sh_dst_beg,
  input  logic [AW-1:0] sh_dst_cur,
  input  logic [CW-1:0] burst_m1,
  input  logic [SW-1:0] src_bstep,
  input  logic [SW-1:0] dst_bstep,
  input  logic [CW-1:0] xfer_len,
  input  logic [SW-1:0] src_xstep,
  input  logic [SW-1:0] dst_xstep,
  input  logic [CW-1:0] src_wrap_len,
  input  logic [SW-1:0] src_wstep,
  input  logic [CW-1:0] dst_wrap_len,
  input  logic [SW-1:0] dst_wstep,
  input  logic          one_shot,
  input  logic          cont_mode,
  input  logic          int_at_end,
  input  logic          int_en,
  input  logic          ovf_int_en,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          busy,
  output logic          ch_int,
  output logic          ovf_flag,
  output logic          ovf_int
);

  localparam logic [CW-1:0] C_ONE = CW'(1);

  logic          running, active, pend, err, hold, first, int_q;
  logic [CW-1:0] wcnt, bleft, swc, dwc;
  logic [AW-1:0] s_cur, s_beg, d_cur, d_beg;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [SW-1:0] st);
    return a + {{(AW-SW){st[SW-1]}}, st};
  endfunction

  logic trig_ok, start, last_word, last_burst, s_wrap, d_wrap;
  assign trig_ok    = trig && running && !hold;
  assign start      = running && !active && pend;
  assign last_word  = active && (wcnt == '0);
  assign last_burst = bleft <= C_ONE;
  assign s_wrap     = swc <= C_ONE;
  assign d_wrap     = dwc <= C_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; active <= 1'b0; pend <= 1'b0; err <= 1'b0;
      hold <= 1'b0; first <= 1'b0; int_q <= 1'b0;
      wcnt <= '0; bleft <= '0; swc <= '0; dwc <= '0;
      s_cur <= '0; s_beg <= '0; d_cur <= '0; d_beg <= '0;
    end else if (hard_rst) begin
      running <= 1'b0; active <= 1'b0; pend <= 1'b0; err <= 1'b0;
      hold <= 1'b1; first <= 1'b0; int_q <= 1'b0;
      wcnt <= '0; bleft <= '0; swc <= '0; dwc <= '0;
    end else begin
      hold  <= 1'b0;
      int_q <= 1'b0;

      if (clr_trig)     pend <= 1'b0;
      else if (trig_ok) pend <= 1'b1;
      else if (start)   pend <= 1'b0;

      if (clr_err)                        err <= 1'b0;
      else if (trig_ok && pend && !start) err <= 1'b1;

      if (run_set && !running && !hold) begin
        running <= 1'b1;
        first   <= 1'b1;
        s_cur <= sh_src_cur; s_beg <= sh_src_beg;
        d_cur <= sh_dst_cur; d_beg <= sh_dst_beg;
        bleft <= xfer_len; swc <= src_wrap_len; dwc <= dst_wrap_len;
      end else if (start) begin
        active <= 1'b1;
        wcnt   <= burst_m1;
        first  <= 1'b0;
        if (first) int_q <= int_en && !int_at_end;
      end else if (active) begin
        if (!last_word) begin
          wcnt  <= wcnt - C_ONE;
          s_cur <= adv(s_cur, src_bstep);
          d_cur <= adv(d_cur, dst_bstep);
        end else begin
          if (s_wrap) begin
            s_beg <= adv(s_beg, src_wstep);
            s_cur <= adv(s_beg, src_wstep);
            swc   <= src_wrap_len;
          end else begin
            s_cur <= adv(s_cur, src_xstep);
            swc   <= swc - C_ONE;
          end
          if (d_wrap) begin
            d_beg <= adv(d_beg, dst_wstep);
            d_cur <= adv(d_beg, dst_wstep);
            dwc   <= dst_wrap_len;
          end else begin
            d_cur <= adv(d_cur, dst_xstep);
            dwc   <= dwc - C_ONE;
          end
          if (last_burst) begin
            active <= 1'b0;
            int_q  <= int_en && int_at_end;
            if (cont_mode) begin
              first <= 1'b1;
              s_cur <= sh_src_cur; s_beg <= sh_src_beg;
              d_cur <= sh_dst_cur; d_beg <= sh_dst_beg;
              bleft <= xfer_len; swc <= src_wrap_len; dwc <= dst_wrap_len;
            end else begin
              running <= 1'b0;
              pend    <= 1'b0;
            end
          end else begin
            bleft <= bleft - C_ONE;
            if (one_shot) wcnt <= burst_m1;
            else          active <= 1'b0;
          end
        end
      end
    end
  end

  assign rd_en    = active;
  assign wr_en    = active;
  assign rd_addr  = s_cur;
  assign wr_addr  = d_cur;
  assign busy     = running;
  assign ch_int   = int_q;
  assign ovf_flag = err;
  assign ovf_int  = err && ovf_int_en;

  AST_HARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (!busy && !rd_en && !ovf_flag)); // R12
  AST_HOLD_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !hard_rst) |=> !busy); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!active && !pend)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_err && !hard_rst) |=> ovf_flag); // R10
  AST_INT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ch_int |=> !ch_int); // R9
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wcnt != '0 && !hard_rst) |=> rd_addr == adv($past(rd_addr), $past(src_bstep))); // R2
  AST_ONESHOT_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_word && one_shot && !last_burst && !hard_rst) |=> rd_en); // R7

endmodule

// File: tb/dma_addr_seq_test.sv
`timescale 1ns/1ps
module dma_addr_seq_test;
  logic clk = 0, rst_n = 0;
  logic hard_rst = 0, run_set = 0, trig = 0, clr_trig = 0, clr_err = 0;
  logic [31:0] sh_src_beg = 0, sh_src_cur = 0, sh_dst_beg = 0, sh_dst_cur = 0;
  logic [15:0] burst_m1 = 0, src_bstep = 0, dst_bstep = 0, xfer_len = 0;
  logic [15:0] src_xstep = 0, dst_xstep = 0, src_wrap_len = 0, src_wstep = 0;
  logic [15:0] dst_wrap_len = 0, dst_wstep = 0;
  logic one_shot = 0, cont_mode = 0, int_at_end = 0, int_en = 0, ovf_int_en = 0;
  logic rd_en, wr_en, busy, ch_int, ovf_flag, ovf_int;
  logic [31:0] rd_addr, wr_addr;

  dma_addr_seq uut (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [31:0] s, d; bit first, last; } item_t;
  item_t q[$];
  int errors = 0, checks = 0;
  bit prev_last = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [31:0] a, logic [15:0] st);
    return a + {{16{st[15]}}, st};
  endfunction

  // model of R2/R3/R4 loops; pushes the first n_push bursts of one transfer
  task automatic gen(int n_push);
    logic [31:0] s = sh_src_cur, sb = sh_src_beg, d = sh_dst_cur, db = sh_dst_beg;
    int sw = src_wrap_len, dw = dst_wrap_len;
    int nb = (xfer_len == 0) ? 1 : xfer_len;
    for (int b = 0; b < n_push; b++) begin
      for (int w = 0; w <= burst_m1; w++) begin
        item_t it;
        it.s = s; it.d = d;
        it.first = (b == 0 && w == 0);
        it.last = (b == nb - 1 && w == burst_m1);
        q.push_back(it);
        if (w < burst_m1) begin s = sx(s, src_bstep); d = sx(d, dst_bstep); end
      end
      if (sw <= 1) begin sb = sx(sb, src_wstep); s = sb; sw = src_wrap_len; end
      else begin s = sx(s, src_xstep); sw--; end
      if (dw <= 1) begin db = sx(db, dst_wstep); d = db; dw = dst_wrap_len; end
      else begin d = sx(d, dst_xstep); dw--; end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit exp_int;
    item_t it;
    exp_int = int_en && int_at_end && prev_last;
    prev_last = 0;
    if (rd_en) begin
      if (q.size() == 0) chk(0, "R2", "unexpected strobe", rd_addr, 0);
      else begin
        it = q.pop_front();
        chk(rd_addr == it.s, "R2/R3/R4", "rd_addr", rd_addr, it.s);
        chk(wr_addr == it.d && wr_en, "R2/R3/R4", "wr_addr", wr_addr, it.d);
        if (int_en && !int_at_end && it.first) exp_int = 1;
        prev_last = it.last;
      end
    end
    if (exp_int || ch_int) chk(ch_int == exp_int, "R9", "ch_int", ch_int, exp_int);
  end

  task automatic tick(int n = 1); repeat (n) @(posedge clk); #1; endtask
  task automatic pulse_run(); run_set = 1; tick(); run_set = 0; endtask
  task automatic pulse_trig(int n = 1); trig = 1; tick(n); trig = 0; endtask
  task automatic drain();
    for (int i = 0; i < 300 && q.size() != 0; i++) tick();
    tick(3);
    chk(q.size() == 0, "R2", "queue drained", q.size(), 0);
  endtask
  task automatic do_hard(); hard_rst = 1; tick(); hard_rst = 0; endtask

  initial begin
    repeat (500000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    @(negedge clk);
    chk(!rd_en && !wr_en && !busy && !ch_int && !ovf_flag && !ovf_int, "R1", "reset outputs",
        {rd_en, wr_en, busy, ch_int, ovf_flag, ovf_int}, 0);
    tick();

    // R6: triggers while stopped are dropped
    pulse_trig(3); tick(2);
    chk(!ovf_flag && !busy, "R6", "stopped trig", {ovf_flag, busy}, 0);

    // basic: 3 words x 3 bursts, negative step across zero
    sh_src_cur = 32'h2; sh_src_beg = 32'h2; sh_dst_cur = 32'h100; sh_dst_beg = 32'h100;
    burst_m1 = 2; src_bstep = 16'hFFFE; dst_bstep = 2; xfer_len = 3;
    src_xstep = 16'h0040; dst_xstep = 16'hFFF8; src_wrap_len = 100; dst_wrap_len = 100;
    pulse_run(); tick(4);
    chk(busy && !rd_en, "R5", "armed, no burst without trigger", {busy, rd_en}, 2'b10);
    gen(3);
    trig = 1; tick(); trig = 0;
    @(negedge clk); chk(rd_en == 0, "R6", "no strobe right after trig edge", rd_en, 0);
    @(negedge clk); chk(rd_en == 1, "R6", "strobe one edge later", rd_en, 1);
    tick(6); pulse_run();
    tick(2); pulse_trig(); tick(8); pulse_trig(); drain();
    chk(!busy, "R8", "stops without continuous", busy, 0);
    pulse_trig(); tick(5);

    // wrap + one-shot + start interrupt; xfer_len 0 acts as 1 afterwards
    sh_src_cur = 32'h1000; sh_src_beg = 32'h1000; sh_dst_cur = 32'h2004; sh_dst_beg = 32'h2000;
    burst_m1 = 1; src_bstep = 1; dst_bstep = 16'hFFFF; xfer_len = 5;
    src_xstep = 16'h10; dst_xstep = 16'h20; src_wrap_len = 2; src_wstep = 16'h40;
    dst_wrap_len = 3; dst_wstep = 16'hFF00; one_shot = 1; int_en = 1; int_at_end = 0;
    pulse_run(); gen(5);
    pulse_trig();
    begin
      int run_len = 0;
      while (!rd_en) @(negedge clk);
      while (rd_en) begin run_len++; @(negedge clk); end
      chk(run_len == 10, "R7", "gapless one-shot length", run_len, 10);
    end
    drain();
    xfer_len = 0; burst_m1 = 0; pulse_run(); gen(1); pulse_trig(); drain();
    chk(!busy, "R3", "zero length is one burst", busy, 0);

    // continuous + end interrupt
    sh_src_cur = 32'h500; sh_src_beg = 32'h500; sh_dst_cur = 32'h600; sh_dst_beg = 32'h600;
    burst_m1 = 1; src_bstep = 4; dst_bstep = 4; xfer_len = 2; src_xstep = 8; dst_xstep = 8;
    src_wrap_len = 50; dst_wrap_len = 50; cont_mode = 1; int_at_end = 1;
    pulse_run(); gen(2); pulse_trig(); drain();
    chk(busy, "R8", "continuous stays armed", busy, 1);
    gen(2); pulse_trig(); drain();
    sh_src_cur = 32'h9999; pulse_run(); tick(2);
    chk(!rd_en && busy, "R5", "run_set while busy ignored", rd_en, 0);
    sh_src_cur = 32'h500;
    do_hard(); tick();
    chk(!busy, "R12", "hard reset idles", busy, 0);
    cont_mode = 0; one_shot = 0; int_en = 0;

    // overflow: 4-word bursts, trigger held over three edges
    burst_m1 = 3; xfer_len = 2; ovf_int_en = 1;
    pulse_run(); gen(2);
    pulse_trig(3); drain();
    chk(ovf_flag && ovf_int, "R10", "overflow set", {ovf_flag, ovf_int}, 2'b11);
    ovf_int_en = 0; tick();
    chk(!ovf_int && ovf_flag, "R10", "ovf_int gated", {ovf_flag, ovf_int}, 2'b10);
    clr_err = 1; trig = 1; tick(); clr_err = 0; trig = 0; tick();
    chk(!ovf_flag, "R10", "clear", ovf_flag, 0);

    // R11: clr_trig drops a pending trigger
    pulse_run(); gen(1);
    pulse_trig(); trig = 1; tick(); trig = 0; clr_trig = 1; tick(); clr_trig = 0;
    drain();
    chk(busy && !ovf_flag, "R11", "no second burst", {busy, ovf_flag}, 2'b10);

    // R12: hard reset then run/trig in the hold cycle
    hard_rst = 1; tick(); hard_rst = 0; run_set = 1; trig = 1; tick(); run_set = 0; trig = 0;
    tick(3);
    chk(!busy && !rd_en, "R12", "hold cycle ignores run", {busy, rd_en}, 0);
    chk(!ovf_flag, "R12", "flags cleared", ovf_flag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule